// File: doc/BRIEF.md
# Event Queue Consumer Dispatcher

This block drains a circular event queue that a peer engine fills in a shared RAM. When a trigger arrives, it walks the queue from its own consumer index. It reads one descriptor at a time through a registered RAM read port. It treats an element as newly written only when the element's phase bit differs from the wrap flag that the block holds locally. Each new element is handed to the handler for its event type, as a request that carries the type, the payload size and the queue slot that holds the payload. The request stays up until the handler acknowledges it.

Per-type qualification comes from three input vectors: enable, busy and handler-present. The block also keeps its own running flag for the type whose request is in flight. A descriptor can be routed elsewhere by its source bit, in which case it is consumed silently. A type with no valid handler raises an unhandled-event error and is still consumed. A type outside the supported range raises an unknown-event error and ends the scan.

At the end of every scan, the block writes the consumer-index register back with a read-modify-write. The written fields are the index, the wrap flag, an armed bit that re-enables the interrupt, and a nibble XOR checksum. After reset, the block first presets every descriptor so that no element looks new. It then performs one initial write-back.

Top module: `evq_drain`

## Requirements
- R1: After reset the block writes every one of the QUEUE_LEN descriptors with the value 0 (phase bit 31 equal to the initial wrap flag 0). It then performs one consumer-index write-back with index 0, wrap 0 and armed 1.
- R2: Descriptor layout is: type in bits 6:0, source in bit 7, size in bits 15:8, phase in bit 31. On a trigger the scan starts at the current consumer index. It stops at the first element whose phase bit equals the local wrap flag, and that element is not consumed.
- R3: A single scan consumes at most QUEUE_LEN elements, even if more new elements are present.
- R4: A type at or above NUM_TYPES raises errValid for one cycle with errUnknown=1 and errType equal to the type. The scan then ends without consuming that element.
- R5: An element with source bit 1 is consumed with neither a dispatch nor an error.
- R6: An element is dispatched only when, for its type, the enable bit is 1, the handler-present bit is 1, the busy bit is 0 and the type is not running. During the dispatch, dispReq stays high with dispType, dispSize and dispSlot (the element's slot) until dispAck. typeRunning is one-hot on that type while dispReq is high and is zero otherwise.
- R7: A supported, non-source element that does not qualify for dispatch raises errValid with errUnknown=0 and errType equal to its type, and is consumed.
- R8: Each consumed element increments the consumer index. On reaching QUEUE_LEN the index returns to 0 and the wrap flag inverts.
- R9: The write-back word carries: the index in bits 19:0, the wrap flag in bit 20, armed=1 in bit 31, and bits 27:24 equal to the XOR of the eight nibbles of the word taken with those four bits at zero.
- R10: All write-back bits outside 19:0, 20, 27:24 and 31 equal the corresponding bits of ciRegCur.
- R11: A trigger that arrives while a scan or write-back is under way causes exactly one further scan and write-back once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| trigger | input | 1 | Interrupt or work trigger pulse |
| ramRdEn | output | 1 | Queue RAM read enable (data valid next cycle) |
| ramRdAddr | output | IDX_W | Queue RAM read slot |
| ramRdData | input | 32 | Queue RAM read descriptor |
| ramWrEn | output | 1 | Queue RAM write enable for descriptor preset |
| ramWrAddr | output | IDX_W | Queue RAM write slot |
| ramWrData | output | 32 | Queue RAM write descriptor |
| typeEnable | input | NUM_TYPES | Per-type enable |
| typeBusy | input | NUM_TYPES | Per-type external busy state |
| handlerPresent | input | NUM_TYPES | Per-type handler registered |
| typeRunning | output | NUM_TYPES | Per-type running flag |
| dispReq | output | 1 | Handler dispatch request |
| dispType | output | 7 | Event type of the dispatch |
| dispSize | output | 8 | Payload size of the dispatch |
| dispSlot | output | IDX_W | Queue slot holding the payload |
| dispAck | input | 1 | Handler acknowledge |
| errValid | output | 1 | Error pulse |
| errUnknown | output | 1 | 1 = unknown type, 0 = unhandled type |
| errType | output | 7 | Type that caused the error |
| ciRegCur | input | 32 | Current consumer-index register value |
| ciWrEn | output | 1 | Consumer-index register write strobe |
| ciWrData | output | 32 | Consumer-index register write value |

## Verification
The hardest case to reach is the per-scan element limit. After a full lap the slot at the start position normally holds a stale phase, so the scan ends on its own before the limit is ever tested. To reach the limit, the bench plays the producer while the scan is in progress: each time a handler acknowledges an element, it rewrites that slot with the phase of the next lap. A full queue of new elements then remains ahead of the consumer, and only the limit can end the scan. The second hard case is a trigger that lands during a scan. The bench creates it by pulsing the trigger while a dispatch is held open by a delayed acknowledge, then checks that exactly two write-backs follow.

// File: rtl/evq_pkg.sv
package evq_pkg;

  // descriptor field positions (decoded by the producing engine as well)
  localparam int TYPE_W    = 7;
  localparam int SRC_BIT   = 7;
  localparam int SIZE_LSB  = 8;
  localparam int SIZE_W    = 8;
  localparam int PHASE_BIT = 31;

  // consumer-index register field positions
  localparam int CI_IDX_W     = 20;
  localparam int CI_WRAP_BIT  = 20;
  localparam int CI_CHK_LSB   = 24;
  localparam int CI_ARMED_BIT = 31;
  localparam logic [31:0] CI_FIELD_MASK = 32'h8F1F_FFFF;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_READ,
    ST_LATCH,
    ST_EVAL,
    ST_DISP,
    ST_WB
  } scanState_t;

  typedef struct packed {
    logic initWrite;
    logic startScan;
    logic readIssue;
    logic latchDesc;
    logic consume;
    logic setRun;
    logic clrRun;
  } ctrlStrobe_t;

  typedef struct packed {
    logic initDone;
    logic phaseNew;
    logic typeUnknown;
    logic srcSkip;
    logic typeReady;
    logic lastInScan;
  } dpStatus_t;

  typedef struct packed {
    logic              phase;
    logic [SIZE_W-1:0] size;
    logic              src;
    logic [TYPE_W-1:0] evType;
  } descFields_t;

  function automatic logic [3:0] nibbleXor(input logic [31:0] word);
    logic [3:0] acc;
    acc = 4'h0;
    for (int n = 0; n < 8; n++) acc = acc ^ word[4*n +: 4];
    return acc;
  endfunction

endpackage

// File: rtl/evq_dpath.sv
module evq_dpath
  import evq_pkg::*;
#(
  parameter int QUEUE_LEN = 16,
  parameter int NUM_TYPES = 8,
  localparam int IDX_W  = $clog2(QUEUE_LEN),
  localparam int CNT_W  = $clog2(QUEUE_LEN + 1),
  localparam int TSEL_W = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  output dpStatus_t            status,
  input  logic [NUM_TYPES-1:0] typeEnable,
  input  logic [NUM_TYPES-1:0] typeBusy,
  input  logic [NUM_TYPES-1:0] handlerPresent,
  output logic [NUM_TYPES-1:0] typeRunning,
  output logic [IDX_W-1:0]     ramRdAddr,
  input  logic [31:0]          ramRdData,
  output logic [IDX_W-1:0]     ramWrAddr,
  output logic [31:0]          ramWrData,
  output logic [TYPE_W-1:0]    dispType,
  output logic [SIZE_W-1:0]    dispSize,
  output logic [IDX_W-1:0]     dispSlot,
  output logic [TYPE_W-1:0]    errType,
  input  logic [31:0]          ciRegCur,
  output logic [31:0]          ciWrData
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(QUEUE_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(QUEUE_LEN - 1);

  logic [IDX_W-1:0]     idxQ;
  logic                 wrapQ;
  logic [CNT_W-1:0]     scanCntQ;
  logic [IDX_W-1:0]     initCntQ;
  descFields_t          descQ;
  logic [NUM_TYPES-1:0] runQ;
  logic [TSEL_W-1:0]    typeSel;
  logic                 unusedDescBits;

  assign unusedDescBits = ^ramRdData[30:16];
  assign typeSel        = descQ.evType[TSEL_W-1:0];

  // consumer index, wrap flag and per-scan element count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      wrapQ    <= 1'b0;
      scanCntQ <= '0;
    end else begin
      if (strobe.startScan) begin
        scanCntQ <= '0;
      end else if (strobe.consume) begin
        scanCntQ <= scanCntQ + 1'b1;
      end
      if (strobe.consume) begin
        if (idxQ == LAST_SLOT) begin
          idxQ  <= '0;
          wrapQ <= ~wrapQ;
        end else begin
          idxQ <= idxQ + 1'b1;
        end
      end
    end
  end

  // descriptor preset walker
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCntQ <= '0;
    end else if (strobe.initWrite && initCntQ != LAST_SLOT) begin
      initCntQ <= initCntQ + 1'b1;
    end
  end

  // descriptor capture stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descQ <= '0;
    end else if (strobe.latchDesc) begin
      descQ.phase  <= ramRdData[PHASE_BIT];
      descQ.size   <= ramRdData[SIZE_LSB +: SIZE_W];
      descQ.src    <= ramRdData[SRC_BIT];
      descQ.evType <= ramRdData[TYPE_W-1:0];
    end
  end

  // running flag of the type in flight
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= '0;
    end else if (strobe.setRun) begin
      runQ[typeSel] <= 1'b1;
    end else if (strobe.clrRun) begin
      runQ[typeSel] <= 1'b0;
    end
  end

  assign typeRunning = runQ;

  always_comb begin
    status.initDone    = (initCntQ == LAST_SLOT);
    status.phaseNew    = (descQ.phase != wrapQ);
    status.typeUnknown = (int'(descQ.evType) >= NUM_TYPES);
    status.srcSkip     = descQ.src;
    status.typeReady   = typeEnable[typeSel] && handlerPresent[typeSel]
                         && !typeBusy[typeSel] && !runQ[typeSel];
    status.lastInScan  = (scanCntQ == LAST_CNT);
  end

  assign ramRdAddr = idxQ;
  assign ramWrAddr = initCntQ;
  assign ramWrData = {wrapQ, 31'h0};
  assign dispType  = descQ.evType;
  assign dispSize  = descQ.size;
  assign dispSlot  = idxQ;
  assign errType   = descQ.evType;

  // read-modify-write image of the consumer-index register
  logic [31:0] ciBase;
  always_comb begin
    ciBase = ciRegCur & ~CI_FIELD_MASK;
    ciBase[CI_IDX_W-1:0]  = CI_IDX_W'(idxQ);
    ciBase[CI_WRAP_BIT]   = wrapQ;
    ciBase[CI_ARMED_BIT]  = 1'b1;
    ciWrData = ciBase;
    ciWrData[CI_CHK_LSB +: 4] = nibbleXor(ciBase);
  end

  // R8
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(idxQ) < QUEUE_LEN);

  // R8
  wrap_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.consume && idxQ == LAST_SLOT) |=> (idxQ == '0 && wrapQ != $past(wrapQ)));

  // R3
  scan_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(scanCntQ) <= QUEUE_LEN);

endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigger,
  input  logic        dispAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        dispReq,
  output logic        errValid,
  output logic        errUnknown,
  output logic        ciWrEn
);

  scanState_t stateQ, stateD;
  logic       pendQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_INIT;
    end else begin
      stateQ <= stateD;
    end
  end

  // a trigger outside the idle state is held for one later scan
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (strobe.startScan) begin
      pendQ <= 1'b0;
    end else if (trigger && stateQ != ST_IDLE) begin
      pendQ <= 1'b1;
    end
  end

  always_comb begin
    stateD     = stateQ;
    strobe     = '0;
    errValid   = 1'b0;
    errUnknown = 1'b0;
    unique case (stateQ)
      ST_INIT: begin
        strobe.initWrite = 1'b1;
        if (status.initDone) stateD = ST_WB;
      end
      ST_IDLE: begin
        if (trigger || pendQ) begin
          strobe.startScan = 1'b1;
          stateD = ST_READ;
        end
      end
      ST_READ: begin
        strobe.readIssue = 1'b1;
        stateD = ST_LATCH;
      end
      ST_LATCH: begin
        strobe.latchDesc = 1'b1;
        stateD = ST_EVAL;
      end
      ST_EVAL: begin
        if (!status.phaseNew) begin
          stateD = ST_WB;
        end else if (status.typeUnknown) begin
          errValid   = 1'b1;
          errUnknown = 1'b1;
          stateD     = ST_WB;
        end else if (status.srcSkip) begin
          strobe.consume = 1'b1;
          stateD = status.lastInScan ? ST_WB : ST_READ;
        end else if (status.typeReady) begin
          strobe.setRun = 1'b1;
          stateD = ST_DISP;
        end else begin
          errValid       = 1'b1;
          strobe.consume = 1'b1;
          stateD = status.lastInScan ? ST_WB : ST_READ;
        end
      end
      ST_DISP: begin
        if (dispAck) begin
          strobe.clrRun  = 1'b1;
          strobe.consume = 1'b1;
          stateD = status.lastInScan ? ST_WB : ST_READ;
        end
      end
      ST_WB: begin
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign dispReq = (stateQ == ST_DISP);
  assign ciWrEn  = (stateQ == ST_WB);

  // R6
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dispReq && !dispAck) |=> dispReq);

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(errValid && (dispReq || ciWrEn)));

  // R11
  pend_rescan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ciWrEn && pendQ) |=> (stateQ == ST_IDLE) ##1 (stateQ == ST_READ));

endmodule

// File: rtl/evq_drain.sv
module evq_drain
  import evq_pkg::*;
#(
  parameter int QUEUE_LEN = 16,
  parameter int NUM_TYPES = 8,
  localparam int IDX_W  = $clog2(QUEUE_LEN),
  localparam int TSEL_W = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigger,
  output logic                 ramRdEn,
  output logic [IDX_W-1:0]     ramRdAddr,
  input  logic [31:0]          ramRdData,
  output logic                 ramWrEn,
  output logic [IDX_W-1:0]     ramWrAddr,
  output logic [31:0]          ramWrData,
  input  logic [NUM_TYPES-1:0] typeEnable,
  input  logic [NUM_TYPES-1:0] typeBusy,
  input  logic [NUM_TYPES-1:0] handlerPresent,
  output logic [NUM_TYPES-1:0] typeRunning,
  output logic                 dispReq,
  output logic [6:0]           dispType,
  output logic [7:0]           dispSize,
  output logic [IDX_W-1:0]     dispSlot,
  input  logic                 dispAck,
  output logic                 errValid,
  output logic                 errUnknown,
  output logic [6:0]           errType,
  input  logic [31:0]          ciRegCur,
  output logic                 ciWrEn,
  output logic [31:0]          ciWrData
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  evq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .trigger    (trigger),
    .dispAck    (dispAck),
    .status     (status),
    .strobe     (strobe),
    .dispReq    (dispReq),
    .errValid   (errValid),
    .errUnknown (errUnknown),
    .ciWrEn     (ciWrEn)
  );

  evq_dpath #(
    .QUEUE_LEN (QUEUE_LEN),
    .NUM_TYPES (NUM_TYPES)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .status         (status),
    .typeEnable     (typeEnable),
    .typeBusy       (typeBusy),
    .handlerPresent (handlerPresent),
    .typeRunning    (typeRunning),
    .ramRdAddr      (ramRdAddr),
    .ramRdData      (ramRdData),
    .ramWrAddr      (ramWrAddr),
    .ramWrData      (ramWrData),
    .dispType       (dispType),
    .dispSize       (dispSize),
    .dispSlot       (dispSlot),
    .errType        (errType),
    .ciRegCur       (ciRegCur),
    .ciWrData       (ciWrData)
  );

  assign ramRdEn = strobe.readIssue;
  assign ramWrEn = strobe.initWrite;

  // R6
  disp_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispReq) |-> $past(typeEnable[dispType[TSEL_W-1:0]]
                             && handlerPresent[dispType[TSEL_W-1:0]]
                             && !typeBusy[dispType[TSEL_W-1:0]]));

  // R6
  running_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispReq ? ($onehot(typeRunning) && typeRunning[dispType[TSEL_W-1:0]])
            : (typeRunning == '0));

  // R9
  ci_checksum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ciWrEn |-> ((ciWrData[3:0] ^ ciWrData[7:4] ^ ciWrData[11:8] ^ ciWrData[15:12]
               ^ ciWrData[19:16] ^ ciWrData[23:20] ^ ciWrData[27:24]
               ^ ciWrData[31:28]) == 4'h0 && ciWrData[31]));

  // R10
  ci_preserve_chk: assert property (@(posedge clk) disable iff (!rstN)
    ciWrEn |-> ((ciWrData & 32'h70E0_0000) == (ciRegCur & 32'h70E0_0000)));

endmodule

// File: tb/evq_drain_tb.sv
`timescale 1ns/1ps
module evq_drain_tb;

  localparam int LEN = 16;
  localparam int NT  = 8;
  localparam int IW  = $clog2(LEN);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          trigger = 1'b0;
  logic          ramRdEn, ramWrEn;
  logic [IW-1:0] ramRdAddr, ramWrAddr;
  logic [31:0]   ramRdData, ramWrData;
  logic [NT-1:0] typeEnable = '1, typeBusy = '0, handlerPresent = '1;
  logic [NT-1:0] typeRunning;
  logic          dispReq, dispAck;
  logic [6:0]    dispType, errType;
  logic [7:0]    dispSize;
  logic [IW-1:0] dispSlot;
  logic          errValid, errUnknown;
  logic [31:0]   ciStore, ciWrData;
  logic          ciWrEn;

  evq_drain #(.QUEUE_LEN(LEN), .NUM_TYPES(NT)) u_dut (
    .clk(clk), .rstN(rstN), .trigger(trigger),
    .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .typeEnable(typeEnable), .typeBusy(typeBusy), .handlerPresent(handlerPresent),
    .typeRunning(typeRunning), .dispReq(dispReq), .dispType(dispType),
    .dispSize(dispSize), .dispSlot(dispSlot), .dispAck(dispAck),
    .errValid(errValid), .errUnknown(errUnknown), .errType(errType),
    .ciRegCur(ciStore), .ciWrEn(ciWrEn), .ciWrData(ciWrData)
  );

  // queue RAM with producer port and lap-refill producer
  logic [31:0]   mem [LEN];
  logic          prodEn = 1'b0;
  logic [IW-1:0] prodAddr = '0;
  logic [31:0]   prodData = '0;
  logic          refillReq = 1'b0;
  int            refillLeft = 0;
  initial for (int i = 0; i < LEN; i++) mem[i] = 32'hDEAD_BEEF;

  always @(posedge clk) begin
    if (ramWrEn) mem[ramWrAddr] <= ramWrData;
    else if (prodEn) mem[prodAddr] <= prodData;
    else if (dispReq && dispAck && refillLeft > 0) mem[dispSlot] <= mem[dispSlot] ^ 32'h8000_0000;
    if (refillReq) refillLeft <= LEN;
    else if (dispReq && dispAck && refillLeft > 0) refillLeft <= refillLeft - 1;
    if (ramRdEn) ramRdData <= mem[ramRdAddr];
  end

  // consumer-index register model
  logic        pokeEn = 1'b0;
  logic [31:0] pokeVal = '0;
  int          wbCount = 0;
  logic [31:0] lastWb = '0;
  always @(posedge clk) begin
    if (!rstN) ciStore <= '0;
    else if (pokeEn) ciStore <= pokeVal;
    else if (ciWrEn) ciStore <= ciWrData;
    if (ciWrEn) begin
      wbCount <= wbCount + 1;
      lastWb  <= ciWrData;
    end
  end

  // handler responder and event logs
  logic [6:0]    logType [256];
  logic [7:0]    logSize [256];
  logic [IW-1:0] logSlot [256];
  int            logCnt = 0;
  logic [6:0]    errTypeLog [256];
  logic          errKindLog [256];
  int            errCnt = 0;
  int            waitCnt = 0;
  logic          runBad = 1'b0;
  initial dispAck = 1'b0;

  always @(posedge clk) begin
    if (dispReq && !dispAck) begin
      if (typeRunning != NT'(1 << dispType)) runBad <= 1'b1;
      if (waitCnt == 1) begin
        dispAck <= 1'b1;
        logType[logCnt[7:0]] <= dispType;
        logSize[logCnt[7:0]] <= dispSize;
        logSlot[logCnt[7:0]] <= dispSlot;
        logCnt  <= logCnt + 1;
        waitCnt <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      dispAck <= 1'b0;
      if (!dispReq && typeRunning != '0) runBad <= 1'b1;
    end
    if (errValid) begin
      errTypeLog[errCnt[7:0]] <= errType;
      errKindLog[errCnt[7:0]] <= errUnknown;
      errCnt <= errCnt + 1;
    end
  end

  int nChecks = 0;
  int nFail = 0;
  int prodIdx = 0;
  bit prodWrap = 1'b0;
  bit timedOut = 1'b0;

  task automatic chk(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ciWord(int idx, bit w, logic [31:0] other);
    logic [31:0] v;
    logic [3:0]  x;
    v = (other & 32'h70E0_0000) | (32'(idx) & 32'h000F_FFFF);
    v[20] = w;
    v[31] = 1'b1;
    x = 4'h0;
    for (int n = 0; n < 8; n++) x ^= v[4*n +: 4];
    v[27:24] = x;
    return v;
  endfunction

  function automatic logic [31:0] descWord(bit ph, bit src, int size, int typ);
    return {ph, 15'h0, 8'(size), src, 7'(typ)};
  endfunction

  task automatic putDesc(int slot, logic [31:0] w);
    @(negedge clk);
    prodEn = 1'b1; prodAddr = IW'(slot); prodData = w;
    @(negedge clk);
    prodEn = 1'b0;
  endtask

  task automatic produce(int typ, bit src, int size);
    putDesc(prodIdx, descWord(~prodWrap, src, size, typ));
    prodIdx++;
    if (prodIdx == LEN) begin
      prodIdx = 0;
      prodWrap = ~prodWrap;
    end
  endtask

  task automatic kick();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  task automatic waitWb(int target);
    while (wbCount < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pokeCi(logic [31:0] v);
    @(negedge clk); pokeEn = 1'b1; pokeVal = v;
    @(negedge clk); pokeEn = 1'b0;
  endtask

  task automatic scanOnce();
    int w;
    w = wbCount;
    kick();
    waitWb(w + 1);
  endtask

  task automatic testInit();
    bit allZero;
    waitWb(1);
    allZero = 1'b1;
    for (int i = 0; i < LEN; i++) if (mem[i] != 32'h0) allZero = 1'b0;
    chk("R1 descriptors preset", allZero, 1);
    chk("R1 initial write-back", lastWb, ciWord(0, 0, 0));
    chk("R1 idle dispReq", dispReq, 0);
    chk("R1 idle errValid", errValid, 0);
  endtask

  task automatic testBasic();
    int b;
    b = logCnt;
    produce(1, 0, 8'h11); produce(2, 0, 8'h22); produce(3, 0, 8'h33);
    scanOnce();
    chk("R2 dispatch count", logCnt - b, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R6 dispatch type", logType[b + k], k + 1);
      chk("R6 dispatch size", logSize[b + k], (k + 1) * 8'h11);
      chk("R6 dispatch slot", logSlot[b + k], k);
    end
    chk("R9 write-back after 3", lastWb, ciWord(3, 0, 0));
    chk("R6 running flag", runBad, 0);
  endtask

  task automatic testSkip();
    int b, e;
    b = logCnt; e = errCnt;
    produce(2, 1, 8'h44); produce(4, 0, 8'h55);
    scanOnce();
    chk("R5 only non-source dispatched", logCnt - b, 1);
    chk("R5 dispatched type", logType[b], 4);
    chk("R5 slot after skip", logSlot[b], 4);
    chk("R5 no error", errCnt - e, 0);
    chk("R5 skipped element consumed", lastWb, ciWord(5, 0, 0));
  endtask

  task automatic testUnhandled();
    int b, e;
    b = logCnt; e = errCnt;
    typeEnable[5] = 1'b0; typeBusy[6] = 1'b1; handlerPresent[7] = 1'b0;
    produce(5, 0, 1); produce(6, 0, 2); produce(7, 0, 3); produce(1, 0, 4);
    scanOnce();
    chk("R7 error count", errCnt - e, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R7 error type", errTypeLog[e + k], 5 + k);
      chk("R7 error kind", errKindLog[e + k], 0);
    end
    chk("R6 only qualified dispatched", logCnt - b, 1);
    chk("R6 qualified type", logType[b], 1);
    chk("R7 unhandled consumed", lastWb, ciWord(9, 0, 0));
    typeEnable = '1; typeBusy = '0; handlerPresent = '1;
  endtask

  task automatic testUnknown();
    int b, e;
    b = logCnt; e = errCnt;
    produce(7'h40, 0, 8'h66); produce(2, 0, 8'h77);
    scanOnce();
    chk("R4 unknown error count", errCnt - e, 1);
    chk("R4 unknown error type", errTypeLog[e], 7'h40);
    chk("R4 unknown error kind", errKindLog[e], 1);
    chk("R4 no dispatch after unknown", logCnt - b, 0);
    chk("R4 unknown not consumed", lastWb, ciWord(9, 0, 0));
    putDesc(9, descWord(1, 0, 8'h99, 3));
    scanOnce();
    chk("R2 resumed dispatch count", logCnt - b, 2);
    chk("R2 resumed first type", logType[b], 3);
    chk("R2 resumed first slot", logSlot[b], 9);
    chk("R2 resumed second slot", logSlot[b + 1], 10);
    chk("R2 resumed write-back", lastWb, ciWord(11, 0, 0));
  endtask

  task automatic testWrap();
    int b;
    b = logCnt;
    for (int k = 0; k < 7; k++) produce(k, 0, k);
    scanOnce();
    chk("R8 dispatches across wrap", logCnt - b, 7);
    chk("R8 slot after wrap", logSlot[b + 5], 0);
    chk("R8 index and flag after wrap", lastWb, ciWord(2, 1, 0));
  endtask

  task automatic testPendAndKeep();
    int w;
    pokeCi(32'h70E0_0000);
    produce(3, 0, 1); produce(4, 0, 2);
    w = wbCount;
    kick();
    while (!dispReq) @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    waitWb(w + 2);
    repeat (20) @(negedge clk);
    chk("R11 exactly one extra scan", wbCount - w, 2);
    chk("R10 other bits kept", lastWb, ciWord(4, 1, 32'h70E0_0000));
  endtask

  task automatic testLimit();
    int b;
    b = logCnt;
    for (int k = 0; k < LEN; k++) produce(k % NT, 0, k);
    @(negedge clk); refillReq = 1'b1;
    @(negedge clk); refillReq = 1'b0;
    scanOnce();
    chk("R3 one scan capped", logCnt - b, LEN);
    for (int k = 0; k < LEN; k++) chk("R3 capped slot order", logSlot[b + k], (4 + k) % LEN);
    chk("R3 write-back after cap", lastWb, ciWord(4, 0, 32'h70E0_0000));
    b = logCnt;
    scanOnce();
    chk("R3 refilled lap drained", logCnt - b, LEN);
    chk("R8 flag back after second lap", lastWb, ciWord(4, 1, 32'h70E0_0000));
    b = logCnt;
    scanOnce();
    chk("R2 empty scan dispatches none", logCnt - b, 0);
    chk("R2 empty scan write-back", lastWb, ciWord(4, 1, 32'h70E0_0000));
    prodWrap = ~prodWrap;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    fork
      begin
        testInit();
        testBasic();
        testSkip();
        testUnhandled();
        testUnknown();
        testWrap();
        testPendAndKeep();
        testLimit();
      end
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule